// File: doc/BRIEF.md
# Serial Frame Address Filter

This block decides, for each incoming serial frame, whether the frame is meant for this node. After a frame begins, the serial receiver hands over the address field one bit at a time on a valid strobe. The block gathers those bits and compares the finished address with four programmable 8-bit match values. When the comparison is done, it raises either an accept pulse or a reject pulse.

A length control picks between two comparison widths. In the short width, the address is one byte and may match any of the four values. In the long width, the address is two bytes and the four values act as two 16-bit addresses. Each of the first two match values has an ignore mask. A mask bit set to 1 removes that bit from the comparison.

The control is a three-state machine:
- `ST_IDLE` is the state after reset.
- `ST_COLLECT` gathers address bits.
- `ST_DONE` holds after a decision until the next frame begins.

Transitions:
- IDLE→COLLECT on a frame start.
- COLLECT→COLLECT on a new frame start, which restarts the address.
- COLLECT→DONE when the last address bit is taken.
- DONE→COLLECT on a frame start.
- Every other case stays in the current state.

Top module: `serial_addr_filter`

## Requirements
- R1: After reset, `accept` and `reject` are both 0.
- R2: In short mode (`len16`=0), the frame is accepted when the 8 gathered bits equal any one of `match_r0`..`match_r3`, subject to the masks of R4. Otherwise it is rejected.
- R3: In long mode (`len16`=1), the frame is accepted when the 16 gathered bits equal {`match_r1`,`match_r0`} or {`match_r3`,`match_r2`}, subject to R4. The higher-numbered value is the upper byte. Otherwise the frame is rejected.
- R4: A 1 in `ign_mask0` excludes that bit position from comparison with `match_r0`. In long mode this mask acts on the low byte of the first pair. `ign_mask1` does the same for `match_r1`, which is the high byte of the first pair in long mode.
- R5: `match_r2` and `match_r3` are always compared on every bit, whatever the masks hold.
- R6: Address bits arrive least significant first. The first valid bit after a frame start is address bit 0. In long mode the first 8 bits form the low byte. Idle cycles between valid bits do not change the result.
- R7: The decision appears one clock after the edge that samples the last address bit. It lasts exactly one cycle, with exactly one of `accept`/`reject` high.
- R8: After a decision, further valid bits are ignored until the next frame start. No second decision is made.
- R9: A frame start clears any bits gathered so far and restarts the address, even in the middle of one. A bit strobed in the same cycle as a frame start is ignored.
- R10: `len16` is sampled on the frame start cycle. Changing it during collection has no effect on that frame.
- R11: Valid bits before the first frame start are ignored and produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle marker that a new frame begins |
| bit_valid | input | 1 | Strobe: `bit_in` carries an address bit |
| bit_in | input | 1 | Serial address bit |
| len16 | input | 1 | 0: one-byte address, 1: two-byte address |
| match_r0 | input | BYTE_W | Match value 0 (masked by `ign_mask0`) |
| match_r1 | input | BYTE_W | Match value 1 (masked by `ign_mask1`) |
| match_r2 | input | BYTE_W | Match value 2, always fully compared |
| match_r3 | input | BYTE_W | Match value 3, always fully compared |
| ign_mask0 | input | BYTE_W | Ignore mask for value 0 |
| ign_mask1 | input | BYTE_W | Ignore mask for value 1 |
| accept | output | 1 | One-cycle pulse: frame is for this node |
| reject | output | 1 | One-cycle pulse: frame is not for this node |

## Verification
The bench builds the block with the default `BYTE_W`=8, so each frame needs 8 or 16 strobed bits. With this width, every match value and both masks can be set to distinct byte patterns. Byte-swapped and cross-pair addresses can then be told apart from true matches, and partial-nibble masks show which value a mask acts on. The short frames also keep restart, start-cycle-bit and post-decision cases to a few cycles each.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DONE    = 2'd2
    } afilt_state_e;
endpackage

// File: rtl/afilt_collect.sv
module afilt_collect #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  take,
    input  logic                  bit_in,
    input  logic                  len16_q,
    output logic [2*BYTE_W-1:0]   cand,
    output logic                  last
);
    localparam int WIDE_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(WIDE_W);

    logic [WIDE_W-1:0] held;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  top_idx;

    assign top_idx = len16_q ? CNT_W'(WIDE_W - 1) : CNT_W'(BYTE_W - 1);

    // candidate address: held bits with the bit being strobed placed at its slot
    always_comb begin
        cand = held;
        if (take) begin
            cand[cnt] = bit_in;
        end
    end

    assign last = take && (cnt == top_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
            cnt  <= '0;
        end else if (clear) begin
            held <= '0;
            cnt  <= '0;
        end else if (take) begin
            held <= cand;
            cnt  <= cnt + CNT_W'(1);
        end
    end

    // R6
    // cnt_range_chk
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt <= top_idx));

endmodule

// File: rtl/afilt_match.sv
module afilt_match #(
    parameter int BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] cand,
    input  logic                len16_q,
    input  logic [BYTE_W-1:0]   match_r0,
    input  logic [BYTE_W-1:0]   match_r1,
    input  logic [BYTE_W-1:0]   match_r2,
    input  logic [BYTE_W-1:0]   match_r3,
    input  logic [BYTE_W-1:0]   ign_mask0,
    input  logic [BYTE_W-1:0]   ign_mask1,
    output logic                hit
);
    localparam int NUM_VAL  = 4;
    localparam int NUM_PAIR = NUM_VAL / 2;

    logic [BYTE_W-1:0] vals [NUM_VAL];
    logic [BYTE_W-1:0] msks [NUM_VAL];
    logic [NUM_VAL-1:0]  narrow_hit;
    logic [NUM_PAIR-1:0] wide_hit;

    assign vals[0] = match_r0;
    assign vals[1] = match_r1;
    assign vals[2] = match_r2;
    assign vals[3] = match_r3;
    assign msks[0] = ign_mask0;
    assign msks[1] = ign_mask1;
    assign msks[2] = '0;
    assign msks[3] = '0;

    for (genvar g = 0; g < NUM_VAL; g++) begin : g_narrow
        assign narrow_hit[g] =
            (((cand[BYTE_W-1:0] ^ vals[g]) & ~msks[g]) == '0);
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_wide
        assign wide_hit[p] =
            (((cand ^ {vals[2*p+1], vals[2*p]}) & ~{msks[2*p+1], msks[2*p]}) == '0);
    end

    assign hit = len16_q ? |wide_hit : |narrow_hit;

    // R5
    always_comb begin
        if (!len16_q && (cand[BYTE_W-1:0] == match_r3)) begin
            r3_exact_chk: assert (hit);
        end
    end

endmodule

// File: rtl/serial_addr_filter.sv
module serial_addr_filter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              len16,
    input  logic [BYTE_W-1:0] match_r0,
    input  logic [BYTE_W-1:0] match_r1,
    input  logic [BYTE_W-1:0] match_r2,
    input  logic [BYTE_W-1:0] match_r3,
    input  logic [BYTE_W-1:0] ign_mask0,
    input  logic [BYTE_W-1:0] ign_mask1,
    output logic              accept,
    output logic              reject
);
    import afilt_pkg::*;

    localparam int WIDE_W = 2 * BYTE_W;

    afilt_state_e      state, state_nx;
    logic              len16_q;
    logic              take;
    logic              last;
    logic              hit;
    logic [WIDE_W-1:0] cand;

    assign take = bit_valid && (state == ST_COLLECT) && !frame_start;

    afilt_collect #(.BYTE_W(BYTE_W)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_start),
        .take    (take),
        .bit_in  (bit_in),
        .len16_q (len16_q),
        .cand    (cand),
        .last    (last)
    );

    afilt_match #(.BYTE_W(BYTE_W)) u_match (
        .cand      (cand),
        .len16_q   (len16_q),
        .match_r0  (match_r0),
        .match_r1  (match_r1),
        .match_r2  (match_r2),
        .match_r3  (match_r3),
        .ign_mask0 (ign_mask0),
        .ign_mask1 (ign_mask1),
        .hit       (hit)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (frame_start) state_nx = ST_COLLECT;
            ST_COLLECT: begin
                if (frame_start)  state_nx = ST_COLLECT;
                else if (last)    state_nx = ST_DONE;
            end
            ST_DONE:    if (frame_start) state_nx = ST_COLLECT;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register and sampled length mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            len16_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (frame_start) begin
                len16_q <= len16;
            end
        end
    end

    // registered decision pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= 1'b0;
            reject <= 1'b0;
        end else begin
            accept <= last && hit;
            reject <= last && !hit;
        end
    end

    // R7
    decision_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |-> ($past(bit_valid) && ($past(state) == ST_COLLECT)
                                && (state == ST_DONE)));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |=> !(accept || reject));

    // R9
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !(accept || reject));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !frame_start) |=> (state == ST_DONE));

endmodule

// File: tb/sim_serial_addr_filter.sv
module sim_serial_addr_filter;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic frame_start;
    logic bit_valid;
    logic bit_in;
    logic len16;
    logic [BW-1:0] r0, r1, r2, r3, m0, m1;
    logic accept, reject;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    serial_addr_filter #(.BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .bit_valid(bit_valid), .bit_in(bit_in), .len16(len16),
        .match_r0(r0), .match_r1(r1), .match_r2(r2), .match_r3(r3),
        .ign_mask0(m0), .ign_mask1(m1),
        .accept(accept), .reject(reject)
    );

    function automatic logic exp_hit(input logic l16, input logic [15:0] a);
        logic h;
        if (!l16) begin
            h = ((a[7:0] & ~m0) == (r0 & ~m0)) || ((a[7:0] & ~m1) == (r1 & ~m1))
                || (a[7:0] == r2) || (a[7:0] == r3);
        end else begin
            h = ((a[7:0] & ~m0) == (r0 & ~m0) && (a[15:8] & ~m1) == (r1 & ~m1))
                || (a == {r3, r2});
        end
        return h;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_frame(input logic l16);
        @(negedge clk);
        frame_start = 1'b1;
        len16 = l16;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic put_bits(input logic [15:0] a, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            bit_valid = 1'b1;
            bit_in = a[i];
            @(negedge clk);
            bit_valid = 1'b0;
            if (i < n - 1) begin
                for (int j = 0; j < gap; j++) @(negedge clk);
            end
        end
    endtask

    task automatic check_dec(input logic exp_acc, input string tag);
        chk(accept == exp_acc && reject == !exp_acc, tag,
            {accept, reject}, {exp_acc, !exp_acc});
        @(negedge clk);
        chk(!accept && !reject, "R7 pulse ends", {accept, reject}, 0);
    endtask

    task automatic check_quiet(input string tag);
        chk(!accept && !reject, tag, {accept, reject}, 0);
    endtask

    task automatic frame(input logic l16, input logic [15:0] a, input string tag);
        start_frame(l16);
        put_bits(a, l16 ? 16 : 8, 0);
        check_dec(exp_hit(l16, a), tag);
    endtask

    task automatic t_reset;
        check_quiet("R1 reset outputs");
        len16 = 1'b0;
        put_bits({8'h00, r0}, 8, 0);
        check_quiet("R11 bits before start");
    endtask

    task automatic t_short;
        m0 = '0; m1 = '0;
        frame(1'b0, {8'h00, r0}, "R2 match r0");
        frame(1'b0, {8'h00, r1}, "R2 match r1");
        frame(1'b0, {8'h00, r2}, "R2 match r2");
        frame(1'b0, {8'h00, r3}, "R2 match r3");
        frame(1'b0, 16'h0000, "R2 no match");
    endtask

    task automatic t_mask;
        m0 = 8'h0F; m1 = 8'hF0;
        frame(1'b0, 16'h0037, "R4 mask0 low nibble ignored");
        frame(1'b0, 16'h0005, "R4 mask1 high nibble ignored");
        frame(1'b0, 16'h004C, "R4 unmasked bits differ");
        m0 = 8'h01; m1 = 8'h01;
        frame(1'b0, {8'h00, r2 ^ 8'h01}, "R5 r2 not masked");
        frame(1'b0, {8'h00, r3 ^ 8'h01}, "R5 r3 not masked");
        m0 = '0; m1 = '0;
    endtask

    task automatic t_wide;
        frame(1'b1, {r1, r0}, "R3 pair0");
        frame(1'b1, {r3, r2}, "R3 pair1");
        frame(1'b1, {r0, r1}, "R6 swapped bytes");
        frame(1'b1, {r2, r0}, "R3 cross pair");
        m0 = 8'hFF;
        frame(1'b1, {r1, 8'h12}, "R4 wide low byte masked");
        frame(1'b1, {r3, 8'h12}, "R5 pair1 unmasked");
        m0 = '0; m1 = 8'h0F;
        frame(1'b1, {r1 ^ 8'h06, r0}, "R4 wide high byte masked");
        m1 = '0;
    endtask

    task automatic t_gaps;
        start_frame(1'b1);
        put_bits({r3, r2}, 16, 2);
        check_dec(1'b1, "R6 gaps between bits");
    endtask

    task automatic t_restart;
        start_frame(1'b0);
        put_bits(16'h00FF, 5, 0);
        start_frame(1'b0);
        put_bits({8'h00, r2}, 8, 0);
        check_dec(1'b1, "R9 restart mid address");
        @(negedge clk);
        frame_start = 1'b1; len16 = 1'b0; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; bit_valid = 1'b0;
        put_bits({8'h00, r2}, 7, 0);
        check_quiet("R9 start-cycle bit ignored");
        put_bits({8'h00, r2} >> 7, 1, 0);
        check_dec(1'b1, "R9 decision after 8 bits");
    endtask

    task automatic t_after_done;
        frame(1'b0, 16'h0000, "R8 first decision");
        put_bits({8'h00, r0}, 8, 0);
        check_quiet("R8 bits after decision");
        put_bits({r1, r0}, 16, 0);
        check_quiet("R8 long run after decision");
    endtask

    task automatic t_len_sample;
        start_frame(1'b0);
        len16 = 1'b1;
        put_bits({8'h00, r0}, 8, 0);
        check_dec(1'b1, "R10 short mode kept");
        start_frame(1'b1);
        len16 = 1'b0;
        put_bits({r1, r0}, 8, 0);
        check_quiet("R10 long mode waits");
        put_bits({8'h00, r1}, 8, 0);
        check_dec(1'b1, "R10 long mode kept");
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_start = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        len16 = 1'b0;
        r0 = 8'h3C; r1 = 8'hA5; r2 = 8'h5A; r3 = 8'hC3; m0 = '0; m1 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_mask();
        t_wide();
        t_gaps();
        t_restart();
        t_after_done();
        t_len_sample();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule